// File: doc/BRIEF.md
# Enable-Synchronized Pixel Clock Divider

This block turns a fast input clock into a pixel clock by dividing it by one of nine moduli (3, 4, 5, 6, 8, 10, 12, 16, 20), chosen by a 4-bit code. The output has a 50/50 duty cycle for every modulus, odd ones included. The odd case uses a half-period retime on the falling edge of the fast clock.

The phase of the pixel clock is controlled by an external enable, typically a conditioned beam-detect pulse. The enable passes through a two-flop synchronizer, and its assertion edge restarts the divider, so the phase is aligned to one fast-clock period. When the enable drops, the running output cycle finishes and the output then holds high. A force-off bit stops the divider in the same way, whatever the enable does. A two-bit mode field can select a board-test mode, in which a static bit drives the output directly.

Top module: `pixclk_div`

## Requirements
- R1: Code to modulus mapping: 0→3, 1→4, 2→4, 3→5, 4→6, 5→8, 6→8, 7→10, 8→12, 9→16, 10→16, 11→20, and 12..15→20.
- R2: Every output cycle of modulus N lasts N fast-clock periods, with N/2 periods low and N/2 high. For even N the low phase starts at the rising edge that begins the cycle. For odd N it starts half a fast-clock period later.
- R3: Suppose the enable becomes active just after rising edge e0 and the divider was parked. The first output cycle then begins at rising edge e0+3. For the late-restart codes 2, 6 and 10, it begins at e0+4. The code that counts here is the one in force at that moment.
- R4: With `en_pol`=1 the enable is active high. With `en_pol`=0 it is active low.
- R5: Suppose the enable goes inactive just after rising edge d0. The first cycle boundary at or after edge d0+3 ends the output. From then on the output stays high until a new assertion.
- R6: Suppose `force_off` is set just after edge f0. The first cycle boundary at or after edge f0+1 parks the output high. If the enable is still active when `force_off` is cleared just after edge f0, that counts as an assertion, and the first cycle begins at edge f0+1 (f0+2 for codes 2, 6, 10).
- R7: With `mode_sel`=2'b11 the output equals `test_lvl` and the divider is ignored. Any other `mode_sel` value gives the divider output.
- R8: After reset the output is high and the divider is parked. The modulus in force is 4 (code 1) until the first cycle boundary.
- R9: A change of `mod_code` is taken only at a cycle boundary, including the boundary that parks the output. A cycle that begins at rising edge t uses the code present just before t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_code | input | 4 | Modulus select code |
| en_in | input | 1 | Asynchronous restart enable |
| en_pol | input | 1 | Enable polarity, 1 = active high |
| force_off | input | 1 | Stops the divider at the next cycle boundary |
| mode_sel | input | 2 | 2'b11 selects board-test mode |
| test_lvl | input | 1 | Output level in test mode |
| pix_clk | output | 1 | Pixel clock |

## Verification
An enable assertion shows up as a falling output edge 3 rising edges later (4 for codes 2, 6, 10), or half a period after that for odd moduli. An enable release ends output at the first boundary 3 edges later, a force-off at the boundary 1 edge later, and a code change at the next boundary. The bench drives every stimulus 1 ns after a rising edge. It then samples the output 1 ns after every rising and falling edge, and compares each half-period sample against a waveform built from these edge counts. The expected waveform tracks which code was latched at the last boundary, because that code sets the first cycle's modulus and latency.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
package pixclk_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 5;
    localparam logic [CODE_W-1:0] RESET_CODE = 4'd1;

    typedef enum logic [1:0] {
        SEL_NORM0 = 2'b00,
        SEL_NORM1 = 2'b01,
        SEL_NORM2 = 2'b10,
        SEL_TEST  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] n;     // modulus in fast-clock periods
        logic             odd;   // needs half-period retime
        logic             slow;  // one extra cycle of restart latency
    } mod_t;

    function automatic mod_t mod_decode(input logic [CODE_W-1:0] c);
        mod_t m;
        m.slow = 1'b0;
        case (c)
            4'd0:  m.n = 5'd3;
            4'd1:  m.n = 5'd4;
            4'd2:  begin m.n = 5'd4;  m.slow = 1'b1; end
            4'd3:  m.n = 5'd5;
            4'd4:  m.n = 5'd6;
            4'd5:  m.n = 5'd8;
            4'd6:  begin m.n = 5'd8;  m.slow = 1'b1; end
            4'd7:  m.n = 5'd10;
            4'd8:  m.n = 5'd12;
            4'd9:  m.n = 5'd16;
            4'd10: begin m.n = 5'd16; m.slow = 1'b1; end
            default: m.n = 5'd20;
        endcase
        m.odd = m.n[0];
        return m;
    endfunction

    // first count value of the high phase: ceil(n/2)
    function automatic logic [CNT_W-1:0] high_start(input mod_t m);
        logic [CNT_W:0] t;
        t = {1'b0, m.n} + 1'b1;
        return t[CNT_W:1];
    endfunction
endpackage

// File: rtl/pixclk_en_sync.sv
`timescale 1ns/1ps
module pixclk_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_pin,
    input  logic en_pol,
    input  logic force_off,
    output logic en_lvl,
    output logic en_rise
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // polarity applied ahead of the synchronizer so a polarity change
    // together with the matching pin change causes no false edge
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) sh_q[i] <= sh_q[i-1];
            sh_q[0] <= ~(en_pin ^ en_pol);
        end
    end

    assign en_lvl  = sh_q[STAGES-1] & ~force_off;
    assign en_rise = en_lvl & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= en_lvl;
    end
endmodule

// File: rtl/pixclk_phase.sv
`timescale 1ns/1ps
module pixclk_phase
    import pixclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              en_lvl,
    input  logic              en_rise,
    output logic              hp_q,
    output logic              odd_sel,
    output logic              run_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CODE_W-1:0] code_q,
    output logic              restart,
    output logic              wrap
);
    mod_t              cur;
    logic              arm_q;
    logic              run_nx;
    logic              hp_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CODE_W-1:0] code_nx;

    assign cur     = mod_decode(code_q);
    assign odd_sel = cur.odd;
    assign restart = cur.slow ? arm_q : en_rise;
    assign wrap    = run_q && (cnt_q == cur.n - 1'b1);

    always_comb begin
        run_nx  = run_q;
        cnt_nx  = cnt_q;
        code_nx = code_q;
        if (restart) begin
            run_nx = 1'b1;
            cnt_nx = '0;
        end else if (wrap) begin
            code_nx = code_in;
            cnt_nx  = '0;
            run_nx  = en_lvl;
        end else if (run_q) begin
            cnt_nx = cnt_q + 1'b1;
        end
        hp_nx = run_nx ? (cnt_nx >= high_start(mod_decode(code_nx))) : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            code_q <= RESET_CODE;
            hp_q   <= 1'b1;
            arm_q  <= 1'b0;
        end else begin
            run_q  <= run_nx;
            cnt_q  <= cnt_nx;
            code_q <= code_nx;
            hp_q   <= hp_nx;
            arm_q  <= en_rise;
        end
    end
endmodule

// File: rtl/pixclk_out_stage.sv
`timescale 1ns/1ps
module pixclk_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic hp_q,
    input  logic odd_sel,
    input  logic test_sel,
    input  logic test_lvl,
    output logic pix_clk
);
    logic hn_q;

    // half-period delayed copy of the rising-edge phase
    always_ff @(negedge clk) begin
        if (rst) hn_q <= 1'b1;
        else     hn_q <= hp_q;
    end

    logic div_out;
    assign div_out = odd_sel ? (hp_q | hn_q) : hp_q;
    assign pix_clk = test_sel ? test_lvl : div_out;
endmodule

// File: rtl/pixclk_div.sv
`timescale 1ns/1ps
module pixclk_div
    import pixclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] mod_code,
    input  logic              en_in,
    input  logic              en_pol,
    input  logic              force_off,
    input  logic [1:0]        mode_sel,
    input  logic              test_lvl,
    output logic              pix_clk
);
    logic              en_lvl_w;
    logic              en_rise_w;
    logic              hp_w;
    logic              odd_w;
    logic              run_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CODE_W-1:0] code_w;
    logic              restart_w;
    logic              wrap_w;
    logic              test_sel_w;

    assign test_sel_w = (mode_e'(mode_sel) == SEL_TEST);

    pixclk_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .en_pin    (en_in),
        .en_pol    (en_pol),
        .force_off (force_off),
        .en_lvl    (en_lvl_w),
        .en_rise   (en_rise_w)
    );

    pixclk_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .code_in (mod_code),
        .en_lvl  (en_lvl_w),
        .en_rise (en_rise_w),
        .hp_q    (hp_w),
        .odd_sel (odd_w),
        .run_q   (run_w),
        .cnt_q   (cnt_w),
        .code_q  (code_w),
        .restart (restart_w),
        .wrap    (wrap_w)
    );

    pixclk_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .hp_q     (hp_w),
        .odd_sel  (odd_w),
        .test_sel (test_sel_w),
        .test_lvl (test_lvl),
        .pix_clk  (pix_clk)
    );
endmodule

// File: rtl/pixclk_div_chk.sv
`timescale 1ns/1ps
module pixclk_div_chk
    import pixclk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic              test_lvl,
    input logic              pix_clk,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CODE_W-1:0] code_q,
    input logic              restart,
    input logic              wrap
);
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < mod_decode(code_q).n));

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
        restart |=> (run_q && cnt_q == '0));

    p_park_high_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_q && mode_sel != 2'b11) |-> pix_clk);

    p_test_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11 && $stable(mode_sel) && $stable(test_lvl)) |-> $stable(pix_clk));

    p_reset_code_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code_q == RESET_CODE));

    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && !wrap && !restart) |=> $stable(code_q));
endmodule

bind pixclk_div pixclk_div_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .test_lvl (test_lvl),
    .pix_clk  (pix_clk),
    .run_q    (run_w),
    .cnt_q    (cnt_w),
    .code_q   (code_w),
    .restart  (restart_w),
    .wrap     (wrap_w)
);

// File: tb/sim_pixclk_div.sv
`timescale 1ns/1ps
module sim_pixclk_div;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mod_code = 4'd1;
    logic       en_in = 1'b0;
    logic       en_pol = 1'b1;
    logic       force_off = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       test_lvl = 1'b0;
    logic       pix_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [3:0] mdl = 4'd1;   // code latched at last boundary (model)

    localparam int HALVES = 160;
    localparam int NEVER  = 1000000;

    always #2.5 clk = ~clk;

    pixclk_div u0 (
        .clk(clk), .rst(rst), .mod_code(mod_code), .en_in(en_in),
        .en_pol(en_pol), .force_off(force_off), .mode_sel(mode_sel),
        .test_lvl(test_lvl), .pix_clk(pix_clk)
    );

    function automatic int tb_n(input logic [3:0] c);
        case (c)
            4'd0: return 3;
            4'd1, 4'd2: return 4;
            4'd3: return 5;
            4'd4: return 6;
            4'd5, 4'd6: return 8;
            4'd7: return 10;
            4'd8: return 12;
            4'd9, 4'd10: return 16;
            default: return 20;
        endcase
    endfunction

    function automatic int tb_slow(input logic [3:0] c);
        return (c == 4'd2 || c == 4'd6 || c == 4'd10) ? 1 : 0;
    endfunction

    // expected level in half-period slot k (slot 0 = 1 ns after edge e0)
    function automatic bit exp_at(input int k, input int p, input int n1,
                                  input int nold, input int nnew,
                                  input int cpos, input int spos);
        int t;
        int n;
        int off;
        t = p;
        if (k < 2 * t) return 1'b1;
        for (int i = 0; i < 64; i++) begin
            n = (i == 0) ? n1 : ((t >= cpos) ? nnew : nold);
            off = n % 2;
            if (k < 2 * t + 2 * n)
                return !((k >= 2 * t + off) && (k < 2 * t + off + n));
            if (t + n >= spos) return 1'b1;
            t = t + n;
        end
        return 1'b1;
    endfunction

    // kind 0: start by enable assertion; kind 1: start by clearing force_off
    // act 1: release enable, 2: set force_off, 3: change code to c2 (at slot act_k)
    task automatic run_case(input string tag, input logic [3:0] c, input bit pol,
                            input int kind, input int act, input int act_k,
                            input logic [3:0] c2);
        int p, n1, nold, nnew, cpos, spos, bad_k;
        bit got, exp_v, bad_got, bad_exp;
        @(posedge clk); #1;
        mod_code = c;
        en_pol = pol;
        en_in = (kind == 1) ? pol : ~pol;
        force_off = (kind == 1);
        repeat (6) @(posedge clk);
        #1;
        p    = ((kind == 0) ? 3 : 1) + tb_slow(mdl);
        n1   = tb_n(mdl);
        nold = tb_n(c);
        nnew = (act == 3) ? tb_n(c2) : nold;
        cpos = (act == 3) ? act_k / 2 + 1 : NEVER;
        spos = (act == 1) ? act_k / 2 + 3 : ((act == 2) ? act_k / 2 + 1 : NEVER);
        if (kind == 0) en_in = pol; else force_off = 1'b0;
        bad_k = -1; bad_got = 0; bad_exp = 0;
        for (int k = 0; k < HALVES; k++) begin
            if (k > 0) #2.5;
            if (k == act_k) begin
                if (act == 1) en_in = ~pol;
                else if (act == 2) force_off = 1'b1;
                else if (act == 3) mod_code = c2;
            end
            got = pix_clk;
            exp_v = exp_at(k, p, n1, nold, nnew, cpos, spos);
            if (got !== exp_v && bad_k < 0) begin
                bad_k = k; bad_got = got; bad_exp = exp_v;
            end
        end
        n_chk++;
        if (bad_k >= 0) begin
            n_bad++;
            $display("FAIL %s code=%0d half=%0d actual=%b expected=%b",
                     tag, c, bad_k, bad_got, bad_exp);
        end
        @(posedge clk); #1;
        en_in = ~pol;
        repeat (5) @(posedge clk);
        #1 force_off = 1'b0;
        repeat (50) @(posedge clk);
        mdl = (act == 3) ? c2 : c;
    endtask

    task automatic check_reset();
        int bad;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            #2.5;
            if (pix_clk !== 1'b1) bad++;
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL R8 reset level actual=%b expected=1", pix_clk);
        end
    endtask

    task automatic check_test_mode();
        int bad;
        @(posedge clk); #1;
        mod_code = 4'd5; en_pol = 1'b1; en_in = 1'b1;
        repeat (12) @(posedge clk);
        for (int lv = 0; lv < 2; lv++) begin
            #1;
            mode_sel = 2'b11;
            test_lvl = lv[0];
            bad = 0;
            for (int k = 0; k < 24; k++) begin
                #2.5;
                if (pix_clk !== lv[0]) bad++;
            end
            n_chk++;
            if (bad != 0) begin
                n_bad++;
                $display("FAIL R7 test level actual=%b expected=%b", pix_clk, lv[0]);
            end
            @(posedge clk);
        end
        #1 mode_sel = 2'b00; test_lvl = 1'b0; en_in = 1'b0;
        repeat (50) @(posedge clk);
        mdl = 4'd5;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        check_reset();                                            // R8
        run_case("R8 R1 R2 default modulus", 4'd0, 1'b1, 0, 1, 40, 4'd0);
        mode_sel = 2'b10;
        run_case("R4 R7 active-low enable", 4'd3, 1'b0, 0, 1, 40, 4'd3);
        mode_sel = 2'b01;
        run_case("R4 R7 active-high enable", 4'd8, 1'b1, 0, 1, 40, 4'd8);
        mode_sel = 2'b00;
        for (int c = 0; c < 16; c++)
            run_case("R1 R2 R3 R5 code sweep", c[3:0], 1'b1, 0, 1, 40, c[3:0]);
        run_case("R9 code change at boundary", 4'd4, 1'b1, 0, 3, 20, 4'd9);
        run_case("R9 change to odd", 4'd10, 1'b1, 0, 3, 34, 4'd3);
        run_case("R6 force stop", 4'd7, 1'b1, 0, 2, 30, 4'd7);
        run_case("R6 force release restart", 4'd7, 1'b1, 1, 1, 40, 4'd7);
        run_case("R6 force release slow code", 4'd6, 1'b1, 1, 1, 40, 4'd6);
        run_case("R6 force release after slow", 4'd0, 1'b1, 1, 1, 40, 4'd0);
        check_test_mode();                                        // R7
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule